// File: doc/BRIEF.md
# DDR SDRAM Start-up Sequencer

This block sits at the front of a DDR SDRAM controller. It takes the memory device from power-up to its ready state. While the board's supplies and clock settle, it holds the clock-enable pin low and deselects the device. Once an input reports that power and clock are stable, it waits a set number of cycles. It then plays out a fixed list of commands on the command and address pins, with a timed gap after each command.

The list of commands is as follows:
- an idle command that also raises clock enable;
- a precharge of every bank;
- a load of the extended mode register that turns on the DLL;
- a load of the base mode register with the DLL reset bit set;
- a second precharge of every bank;
- two refresh cycles;
- a final load of the base mode register with the DLL reset bit cleared.

The ready flag then rises. It never rises sooner than a set lockout after the DLL reset load, so that no read can reach the device too early. Every wait is a parameter in clock cycles. The two mode register values are inputs.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst` is high, while `pwr_ok` is low and during the power-up wait, `cke` is low, `cs_n` is high (deselect) and `done` is low.
- R2: If `pwr_ok` is first sampled high in cycle s and then stays high, `cke` rises in cycle s+T_PWRUP together with a NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1). If `pwr_ok` drops before then, the wait restarts from the beginning.
- R3: Once `cke` is high, it stays high until `rst`.
- R4: After the NOP, the non-NOP commands come in exactly this order: PRECHARGE (ras_n,cas_n,we_n = 0,1,0), LOAD MODE (0,0,0), LOAD MODE, PRECHARGE, AUTO REFRESH (0,0,1), AUTO REFRESH, LOAD MODE. NOPs fill every gap between them.
- R5: Every PRECHARGE drives address bit 10 high and all other address bits and `ba` low. The next command follows exactly T_RP cycles later.
- R6: The first LOAD MODE goes to the extended register, with `ba` = 2'b01 and address = `emr_val`. The other two LOAD MODE commands use `ba` = 2'b00.
- R7: The second LOAD MODE drives `mr_val` with bit DLL_BIT forced to 1. The last LOAD MODE drives `mr_val` with bit DLL_BIT forced to 0.
- R8: The NOP is followed by the first PRECHARGE after 1 cycle. Each LOAD MODE is followed by the next command after exactly T_MRD cycles. Each AUTO REFRESH is followed by the next command after exactly T_RFC cycles. AUTO REFRESH drives address and `ba` low.
- R9: `done` rises in cycle max(L+T_MRD, D+T_DLL), where L is the cycle of the last LOAD MODE and D is the cycle of the DLL-reset LOAD MODE. It is never high earlier.
- R10: Once `done` is high, it stays high. The pins then carry NOP with `ba` and address at zero.
- R11: A synchronous `rst` at any point forces `cke` low and `done` low from the next cycle on. The whole sequence then restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_ok | input | 1 | Supplies and clock are stable |
| emr_val | input | ROW_W | Value for the extended mode register (DLL enabled) |
| mr_val | input | ROW_W | Operating parameters for the base mode register |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ROW_W | Address bus |
| done | output | 1 | Device ready for normal operation |

## Verification
The hardest case to reach is the choice of which limit releases `done`: the DLL lockout or the gap after the last mode load. One parameter set only ever shows one of the two. The bench therefore runs two copies side by side on the same pins. One has a lockout longer than the rest of the sequence and one has a shorter lockout, so each branch of R9 is timed to the exact cycle. The stimulus also covers other conditions that are hard to reach from the ports: a `pwr_ok` pulse that ends partway through the wait, resets dropped at random points in mid-sequence, and mode values that already have the DLL reset bit set or cleared.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int ROW_W   = 13,
  parameter int T_PWRUP = 20000,
  parameter int T_RP    = 3,
  parameter int T_MRD   = 2,
  parameter int T_RFC   = 10,
  parameter int T_DLL   = 200,
  parameter int DLL_BIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_ok,
  input  logic [ROW_W-1:0] emr_val,
  input  logic [ROW_W-1:0] mr_val,
  output logic             cke,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [1:0]       ba,
  output logic [ROW_W-1:0] addr,
  output logic             done
);
  localparam int M1 = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int M2 = (M1 > T_RFC) ? M1 : T_RFC;
  localparam int M3 = (M2 > T_PWRUP) ? M2 : T_PWRUP;
  localparam int CW = $clog2(M3 + 1);
  localparam int LW = $clog2(T_DLL + 1);
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] PW_L  = CW'(T_PWRUP - 1);
  localparam logic [LW-1:0] DLL_L = LW'(T_DLL);
  localparam logic [ROW_W-1:0] DLL_M = ROW_W'(1) << DLL_BIT;

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_NOP, S_PRE1, S_EMR, S_MRR,
    S_PRE2, S_REF1, S_REF2, S_MRN, S_GAP, S_RUN
  } st_t;

  st_t st, nxt_q, after;
  logic [CW-1:0] cnt, gap;
  logic [LW-1:0] lcnt;

  always_comb begin
    after = S_RUN;
    gap   = ONE;
    case (st)
      S_NOP:  begin after = S_PRE1; gap = ONE;          end
      S_PRE1: begin after = S_EMR;  gap = CW'(T_RP);    end
      S_EMR:  begin after = S_MRR;  gap = CW'(T_MRD);   end
      S_MRR:  begin after = S_PRE2; gap = CW'(T_MRD);   end
      S_PRE2: begin after = S_REF1; gap = CW'(T_RP);    end
      S_REF1: begin after = S_REF2; gap = CW'(T_RFC);   end
      S_REF2: begin after = S_MRN;  gap = CW'(T_RFC);   end
      S_MRN:  begin after = S_RUN;  gap = CW'(T_MRD);   end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      nxt_q <= S_IDLE;
      cnt   <= '0;
      lcnt  <= '0;
    end else begin
      if (st == S_MRR) lcnt <= LW'(1);
      else if (lcnt != '0 && lcnt < DLL_L) lcnt <= lcnt + LW'(1);
      case (st)
        S_IDLE: if (pwr_ok) begin
          st  <= S_PWR;
          cnt <= PW_L;
        end
        S_PWR: begin
          if (!pwr_ok) st <= S_IDLE;
          else if (cnt <= ONE) st <= S_NOP;
          else cnt <= cnt - ONE;
        end
        S_GAP: begin
          if (cnt <= ONE) st <= nxt_q;
          else cnt <= cnt - ONE;
        end
        S_RUN: ;
        default: begin
          nxt_q <= after;
          cnt   <= gap - ONE;
          st    <= (gap > ONE) ? S_GAP : after;
        end
      endcase
    end
  end

  assign cke  = !(st == S_IDLE || st == S_PWR);
  assign cs_n = !cke;
  assign done = (st == S_RUN) && (lcnt >= DLL_L);

  always_comb begin
    {ras_n, cas_n, we_n} = 3'b111;
    ba   = 2'b00;
    addr = '0;
    case (st)
      S_PRE1, S_PRE2: begin
        {ras_n, cas_n, we_n} = 3'b010;
        addr[10] = 1'b1;
      end
      S_REF1, S_REF2: {ras_n, cas_n, we_n} = 3'b001;
      S_EMR: begin
        {ras_n, cas_n, we_n} = 3'b000;
        ba   = 2'b01;
        addr = emr_val;
      end
      S_MRR: begin
        {ras_n, cas_n, we_n} = 3'b000;
        addr = mr_val | DLL_M;
      end
      S_MRN: begin
        {ras_n, cas_n, we_n} = 3'b000;
        addr = mr_val & ~DLL_M;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int ROW_W   = 13,
  parameter int T_DLL   = 200,
  parameter int DLL_BIT = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cke,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [1:0]       ba,
  input logic [ROW_W-1:0] addr,
  input logic             done
);
  localparam int LW = $clog2(T_DLL + 1);
  localparam logic [LW-1:0] DL = LW'(T_DLL);

  logic nop, pre, lmr;
  assign nop = !cs_n && ras_n && cas_n && we_n;
  assign pre = !cs_n && !ras_n && cas_n && !we_n;
  assign lmr = !cs_n && !ras_n && !cas_n && !we_n;

  logic armed;
  logic [LW-1:0] since;
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      since <= '0;
    end else if (lmr && ba == 2'b00 && addr[DLL_BIT]) begin
      armed <= 1'b1;
      since <= LW'(1);
    end else if (armed && since < DL) begin
      since <= since + LW'(1);
    end
  end

  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (cs_n && !done));
  // R3
  cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);
  // R5
  pre_all_chk: assert property (@(posedge clk) disable iff (rst)
    pre |-> addr[10]);
  // R6
  lmr_bank_chk: assert property (@(posedge clk) disable iff (rst)
    lmr |-> (ba == 2'b00 || ba == 2'b01));
  // R9
  dll_lockout_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (armed && since >= DL));
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (nop && ba == 2'b00 && addr == '0));
  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!cke && !done));
endmodule

bind ddr_init_seq ddr_init_seq_chk #(
  .ROW_W(ROW_W), .T_DLL(T_DLL), .DLL_BIT(DLL_BIT)
) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .done(done)
);

// File: tb/sim_ddr_init_seq.sv
module sim_ddr_init_seq;
  localparam int RW = 13, TPW = 40, TRP = 3, TMRD = 2, TRFC = 9;
  localparam int TDA = 30, TDB = 10, DB = 8;

  logic clk = 1'b0, rst = 1'b1, pwr_ok = 1'b0;
  logic [RW-1:0] emr_v = '0, mr_v = '0;
  logic a_cke, a_cs_n, a_ras_n, a_cas_n, a_we_n, a_done;
  logic b_cke, b_cs_n, b_ras_n, b_cas_n, b_we_n, b_done;
  logic [1:0] a_ba, b_ba;
  logic [RW-1:0] a_addr, b_addr;
  wire [2:0] a_rcw = {a_ras_n, a_cas_n, a_we_n};

  ddr_init_seq #(.ROW_W(RW), .T_PWRUP(TPW), .T_RP(TRP), .T_MRD(TMRD),
    .T_RFC(TRFC), .T_DLL(TDA), .DLL_BIT(DB)) u0 (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .emr_val(emr_v), .mr_val(mr_v),
    .cke(a_cke), .cs_n(a_cs_n), .ras_n(a_ras_n), .cas_n(a_cas_n),
    .we_n(a_we_n), .ba(a_ba), .addr(a_addr), .done(a_done));

  ddr_init_seq #(.ROW_W(RW), .T_PWRUP(TPW), .T_RP(TRP), .T_MRD(TMRD),
    .T_RFC(TRFC), .T_DLL(TDB), .DLL_BIT(DB)) u1 (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .emr_val(emr_v), .mr_val(mr_v),
    .cke(b_cke), .cs_n(b_cs_n), .ras_n(b_ras_n), .cas_n(b_cas_n),
    .we_n(b_we_n), .ba(b_ba), .addr(b_addr), .done(b_done));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int gap_before(input int i);
    case (i)
      0: return 1;
      1: return TRP;
      2: return TMRD;
      3: return TMRD;
      4: return TRP;
      5: return TRFC;
      default: return TRFC;
    endcase
  endfunction

  function automatic int exp_rcw(input int i);
    case (i)
      0, 3: return 3'b010;
      4, 5: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int exp_addr(input int i, input int emr, input int mr);
    case (i)
      0, 3: return 1 << 10;
      1: return emr;
      2: return mr | (1 << DB);
      6: return mr & ~(1 << DB);
      default: return 0;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    pwr_ok = 1'b0;
    repeat (3) @(negedge clk);
    chk(a_cke == 1'b0 && a_cs_n == 1'b1 && a_done == 1'b0, "R1",
        "reset pins {cke,cs_n,done}", {a_cke, a_cs_n, a_done}, 3'b010);
    rst = 1'b0;
  endtask

  task automatic run(input int glitch, input int abort_at,
                     input logic [RW-1:0] emr, input logic [RW-1:0] mr);
    int t0, c0, ev_n, da, db, e;
    int ev_cyc[7], ev_rcw[7], ev_ba[7], ev_addr[7];
    bit seen, dropped;
    do_reset();
    emr_v = emr;
    mr_v  = mr;
    repeat (2 + $urandom % 5) @(negedge clk);
    chk(a_cke == 1'b0 && a_cs_n == 1'b1, "R1", "idle without pwr_ok",
        {a_cke, a_cs_n}, 2'b01);
    if (glitch > 0) begin
      pwr_ok = 1'b1;
      repeat (glitch) @(negedge clk);
      pwr_ok = 1'b0;
      @(negedge clk);
      chk(a_cke == 1'b0 && a_cs_n == 1'b1, "R2", "cke after short pwr_ok",
          a_cke, 0);
    end
    t0 = cyc;
    pwr_ok = 1'b1;
    if (abort_at > 0) begin
      repeat (abort_at) @(negedge clk);
      chk(a_cke == 1'b1, "R3", "cke before mid reset", a_cke, 1);
      rst = 1'b1;
      @(negedge clk);
      chk(a_cke == 1'b0 && a_done == 1'b0 && b_cke == 1'b0, "R11",
          "cke/done after mid reset", {a_cke, a_done}, 0);
      rst = 1'b0;
      return;
    end
    seen = 0; dropped = 0; ev_n = 0; da = -1; db = -1; c0 = -1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!seen) begin
        if (a_cke) begin
          seen = 1;
          c0 = cyc;
          chk(a_cs_n == 1'b0 && a_rcw == 3'b111, "R2", "command at cke rise",
              {a_cs_n, a_rcw}, 4'b0111);
        end
      end else if (!a_cke) dropped = 1;
      if (a_cke && !a_cs_n && a_rcw != 3'b111) begin
        if (ev_n < 7) begin
          ev_cyc[ev_n]  = cyc;
          ev_rcw[ev_n]  = int'(a_rcw);
          ev_ba[ev_n]   = int'(a_ba);
          ev_addr[ev_n] = int'(a_addr);
        end
        ev_n++;
      end
      if (a_done && da < 0) da = cyc;
      if (b_done && db < 0) db = cyc;
      if (da >= 0 && db >= 0) break;
    end
    chk(c0 == t0 + TPW, "R2", "cke rise cycle", c0, t0 + TPW);
    chk(!dropped, "R3", "cke stayed high", int'(dropped), 0);
    chk(ev_n == 7, "R4", "command count", ev_n, 7);
    e = t0 + TPW;
    for (int i = 0; i < 7; i++) begin
      e = e + gap_before(i);
      if (i < ev_n) begin
        chk(ev_rcw[i] == exp_rcw(i), "R4", $sformatf("command %0d", i),
            ev_rcw[i], exp_rcw(i));
        chk(ev_ba[i] == ((i == 1) ? 1 : 0), "R6", $sformatf("bank %0d", i),
            ev_ba[i], (i == 1) ? 1 : 0);
        chk(ev_addr[i] == exp_addr(i, int'(emr), int'(mr)),
            (i == 0 || i == 3) ? "R5" : ((i == 1) ? "R6" : "R7"),
            $sformatf("address %0d", i), ev_addr[i],
            exp_addr(i, int'(emr), int'(mr)));
        chk(ev_cyc[i] == e, (i == 1 || i == 4) ? "R5" : "R8",
            $sformatf("cycle of command %0d", i), ev_cyc[i], e);
      end
    end
    begin
      int l_c, d_c, ea;
      d_c = t0 + TPW + 1 + TRP + TMRD;
      l_c = e;
      ea = (l_c + TMRD > d_c + TDA) ? l_c + TMRD : d_c + TDA;
      chk(da == ea, "R9", "done cycle, lockout bound", da, ea);
      chk(db == l_c + TMRD, "R9", "done cycle, gap bound", db, l_c + TMRD);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(a_done && !a_cs_n && a_rcw == 3'b111 && a_ba == 2'b00 && a_addr == '0,
          "R10", "idle after done", {a_done, a_rcw}, 4'b1111);
    end
  endtask

  initial begin
    void'($urandom(32'd4321));
    run(0, 0, RW'($urandom), RW'($urandom));
    run(5, 0, '1, '1);
    run(0, 0, '0, '0);
    run(0, TPW + 20, RW'($urandom), RW'($urandom));
    run(0, 0, RW'($urandom), RW'(1 << DB));
    for (int n = 0; n < 8; n++) begin
      int g, a;
      g = ($urandom % 2 == 0) ? 1 + $urandom % (TPW - 5) : 0;
      a = ($urandom % 3 == 0) ? TPW + 2 + $urandom % 50 : 0;
      run(g, a, RW'($urandom), RW'($urandom));
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 60000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule